// File: doc/BRIEF.md
# Configuration File Header Section Parser

This block sits in front of a device-configuration loader and inspects the opening bytes of a stored configuration file as they arrive one byte per valid/ready beat. It first checks a fixed 13-byte signature. If the file instead opens with the three-byte signature of a compressed stream, it reports that and stops, because decompression happens elsewhere.

After a good signature the block walks a chain of header sections. Each section is one ASCII type byte, then a big-endian length, then that many content bytes. Sections that were not requested are consumed and thrown away. When the requested section's header is complete, the block raises `found`, presents the section length, and forwards exactly that many following bytes to its output port. The loader uses these bytes as the raw configuration payload.

Malformed headers raise `err` and the block stops taking input until the next reset. A malformed header is an unknown type, an oversized short length, a signature mismatch, or a search that runs past the byte budget.

Top module: `bitfile_section_parser`

## Requirements
- R1: The file must begin with the bytes 00 09 0F F0 0F F0 0F F0 0F F0 00 00 01, in that order. A mismatch on any of these bytes sets `err` from the clock edge that accepts the bad byte. From then on `in_ready` stays low until reset.
- R2: If the first three bytes are 1F 8B 08, `compressed` rises on the edge that accepts the third byte. `err` stays low, and no further byte is accepted.
- R3: After the signature, each section is a type byte, a big-endian length and its content bytes. Type 0x65 ('e') carries a 4-byte length. Types 0x61 to 0x64 carry a 2-byte length. The requested type is 0x61 + `sect_sel`, where `sect_sel` is 0 to 4.
- R4: A type byte outside 0x61 to 0x65 sets `err`.
- R5: A section of type 'a' to 'd' whose length exceeds 255 sets `err` once its second length byte is accepted.
- R6: A section that does not match the request is skipped by consuming its content bytes. A zero-length section has no content. Walking then continues with the next type byte.
- R7: At most SEARCH_LIMIT (default 100) bytes are consumed after the signature while searching. If the byte numbered SEARCH_LIMIT does not complete the requested section's header, `err` rises. If it does complete that header, the section is found.
- R8: When the requested header completes, `found` rises and `pay_len` shows the section length. Both hold until reset, and `pay_len` reads 0 while `found` is low.
- R9: While forwarding, `out_valid` follows `in_valid`, `out_data` follows `in_data`, and `in_ready` follows `out_ready`. Exactly `pay_len` bytes are forwarded, after which `in_ready` stays low. A zero length forwards nothing.
- R10: After reset, `in_ready` is high and `found`, `err`, `compressed` and `out_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sect_sel | input | 3 | Requested section, 0 to 4 selecting 'a' to 'e' |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_ready | output | 1 | Input byte accepted when high with in_valid |
| out_valid | output | 1 | Payload byte valid |
| out_data | output | 8 | Payload byte |
| out_ready | input | 1 | Downstream accepts the payload byte |
| found | output | 1 | Requested section header located |
| pay_len | output | 32 | Length of the located section |
| err | output | 1 | Format error or search exhausted |
| compressed | output | 1 | Compressed-stream signature detected |

## Verification
The assertions assume three things about the inputs. `sect_sel` is held constant from reset until the run ends. It never exceeds 4. The source does not withdraw `out_ready` in the middle of a cycle.

The stimulus resets the block before every file and sets the selector during reset. It drives `in_valid`, `in_data` and `out_ready` only just after a rising edge.

The downstream ready follows a fixed on/off pattern, so the stalls in the payload phase exercise the follow-through rule. The sticky flags and the stable length are then checked across those stalls.

// File: rtl/bsp_pkg.sv
package bsp_pkg;

    localparam int MAGIC_LEN = 13;
    localparam int GZ_LEN    = 3;

    typedef enum logic [2:0] {
        ST_MAGIC = 3'd0,
        ST_TYPE  = 3'd1,
        ST_LEN   = 3'd2,
        ST_SKIP  = 3'd3,
        ST_PAY   = 3'd4,
        ST_DONE  = 3'd5,
        ST_FAIL  = 3'd6,
        ST_GZIP  = 3'd7
    } bsp_state_e;

endpackage

// File: rtl/bsp_magic_rom.sv
module bsp_magic_rom #(
    parameter int IDX_W = 4
) (
    input  logic [IDX_W-1:0] idx,
    input  logic [7:0]       byte_i,
    output logic             magic_ok,
    output logic             magic_last,
    output logic             gzip_ok,
    output logic             gzip_last
);
    import bsp_pkg::*;

    logic [7:0] magic_exp;
    logic [7:0] gzip_exp;

    // Signature: 00 09, four repeats of 0F F0, then 00 00 01
    always_comb begin
        if (idx == IDX_W'(0))
            magic_exp = 8'h00;
        else if (idx == IDX_W'(1))
            magic_exp = 8'h09;
        else if (idx <= IDX_W'(9))
            magic_exp = idx[0] ? 8'hF0 : 8'h0F;
        else if (idx == IDX_W'(MAGIC_LEN - 1))
            magic_exp = 8'h01;
        else
            magic_exp = 8'h00;
    end

    always_comb begin
        case (idx)
            IDX_W'(0): gzip_exp = 8'h1F;
            IDX_W'(1): gzip_exp = 8'h8B;
            default:   gzip_exp = 8'h08;
        endcase
    end

    assign magic_ok   = (byte_i == magic_exp);
    assign magic_last = (idx == IDX_W'(MAGIC_LEN - 1));
    assign gzip_ok    = (byte_i == gzip_exp);
    assign gzip_last  = (idx == IDX_W'(GZ_LEN - 1));

endmodule

// File: rtl/bsp_type_dec.sv
module bsp_type_dec (
    input  logic [7:0] byte_i,
    input  logic [2:0] sel,
    output logic       type_ok,
    output logic       type_long,
    output logic       type_hit
);
    localparam logic [7:0] FIRST_T = 8'h61;
    localparam logic [7:0] LAST_T  = 8'h65;

    logic [7:0] want;

    assign want      = FIRST_T + {5'd0, sel};
    assign type_ok   = (byte_i >= FIRST_T) && (byte_i <= LAST_T);
    assign type_long = (byte_i == LAST_T);
    assign type_hit  = type_ok && (byte_i == want);

endmodule

// File: rtl/bsp_pay_port.sv
module bsp_pay_port #(
    parameter int DW = 8
) (
    input  logic          active,
    input  logic          in_valid,
    input  logic [DW-1:0] in_data,
    input  logic          out_ready,
    output logic          out_valid,
    output logic [DW-1:0] out_data,
    output logic          ready_o
);
    assign out_valid = active && in_valid;
    assign out_data  = active ? in_data : '0;
    assign ready_o   = active && out_ready;

endmodule

// File: rtl/bitfile_section_parser.sv
module bitfile_section_parser #(
    parameter int SEARCH_LIMIT = 100,
    parameter int LEN_W        = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       sect_sel,
    input  logic             in_valid,
    input  logic [7:0]       in_data,
    output logic             in_ready,
    output logic             out_valid,
    output logic [7:0]       out_data,
    input  logic             out_ready,
    output logic             found,
    output logic [LEN_W-1:0] pay_len,
    output logic             err,
    output logic             compressed
);
    import bsp_pkg::*;

    localparam int IDX_W = $clog2(MAGIC_LEN);
    localparam int CNT_W = $clog2(SEARCH_LIMIT + 1);
    localparam logic [CNT_W-1:0] LIM_C = CNT_W'(SEARCH_LIMIT);

    typedef struct packed {
        bsp_state_e       st;
        logic [IDX_W-1:0] idx;
        logic             gz;
        logic             is_long;
        logic             hit;
        logic [2:0]       lrem;
        logic [LEN_W-1:0] len;
        logic [LEN_W-1:0] rem;
        logic [CNT_W-1:0] cnt;
    } regs_t;

    localparam regs_t RST_V = '{st: ST_MAGIC, idx: '0, gz: 1'b0, is_long: 1'b0,
                                hit: 1'b0, lrem: '0, len: '0, rem: '0, cnt: '0};

    regs_t r_q, r_d;

    logic magic_ok, magic_last, gzip_ok, gzip_last;
    logic type_ok, type_long, type_hit;
    logic pay_ready, walk_ready, acc;
    logic [CNT_W-1:0] cnt_nx;
    logic [LEN_W-1:0] len_nx;

    bsp_magic_rom #(.IDX_W(IDX_W)) u_magic (
        .idx        (r_q.idx),
        .byte_i     (in_data),
        .magic_ok   (magic_ok),
        .magic_last (magic_last),
        .gzip_ok    (gzip_ok),
        .gzip_last  (gzip_last)
    );

    bsp_type_dec u_type (
        .byte_i    (in_data),
        .sel       (sect_sel),
        .type_ok   (type_ok),
        .type_long (type_long),
        .type_hit  (type_hit)
    );

    bsp_pay_port #(.DW(8)) u_pay (
        .active    (r_q.st == ST_PAY),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_data  (out_data),
        .ready_o   (pay_ready)
    );

    assign walk_ready = (r_q.st == ST_MAGIC) || (r_q.st == ST_TYPE) ||
                        (r_q.st == ST_LEN)   || (r_q.st == ST_SKIP);
    assign in_ready   = walk_ready || pay_ready;
    assign acc        = in_valid && in_ready;
    assign cnt_nx     = r_q.cnt + CNT_W'(1);
    assign len_nx     = {r_q.len[LEN_W-9:0], in_data};

    always_comb begin
        r_d = r_q;
        if (acc) begin
            case (r_q.st)
                ST_MAGIC: begin
                    if (r_q.idx == '0) begin
                        if (magic_ok) begin
                            r_d.idx = r_q.idx + IDX_W'(1);
                        end else if (gzip_ok) begin
                            r_d.gz  = 1'b1;
                            r_d.idx = r_q.idx + IDX_W'(1);
                        end else begin
                            r_d.st = ST_FAIL;
                        end
                    end else if (r_q.gz) begin
                        if (!gzip_ok)       r_d.st = ST_FAIL;
                        else if (gzip_last) r_d.st = ST_GZIP;
                        else                r_d.idx = r_q.idx + IDX_W'(1);
                    end else begin
                        if (!magic_ok) begin
                            r_d.st = ST_FAIL;
                        end else if (magic_last) begin
                            r_d.st  = ST_TYPE;
                            r_d.cnt = '0;
                        end else begin
                            r_d.idx = r_q.idx + IDX_W'(1);
                        end
                    end
                end
                ST_TYPE: begin
                    r_d.cnt = cnt_nx;
                    if (!type_ok || cnt_nx == LIM_C) begin
                        r_d.st = ST_FAIL;
                    end else begin
                        r_d.st      = ST_LEN;
                        r_d.is_long = type_long;
                        r_d.hit     = type_hit;
                        r_d.lrem    = type_long ? 3'd4 : 3'd2;
                        r_d.len     = '0;
                    end
                end
                ST_LEN: begin
                    r_d.cnt  = cnt_nx;
                    r_d.len  = len_nx;
                    r_d.lrem = r_q.lrem - 3'd1;
                    if (r_q.lrem == 3'd1) begin
                        if (!r_q.is_long && len_nx[LEN_W-1:8] != '0) begin
                            r_d.st = ST_FAIL;
                        end else if (r_q.hit) begin
                            r_d.rem = len_nx;
                            r_d.st  = (len_nx == '0) ? ST_DONE : ST_PAY;
                        end else if (cnt_nx == LIM_C) begin
                            r_d.st = ST_FAIL;
                        end else if (len_nx == '0) begin
                            r_d.st = ST_TYPE;
                        end else begin
                            r_d.rem = len_nx;
                            r_d.st  = ST_SKIP;
                        end
                    end else if (cnt_nx == LIM_C) begin
                        r_d.st = ST_FAIL;
                    end
                end
                ST_SKIP: begin
                    r_d.cnt = cnt_nx;
                    r_d.rem = r_q.rem - LEN_W'(1);
                    if (cnt_nx == LIM_C)           r_d.st = ST_FAIL;
                    else if (r_q.rem == LEN_W'(1)) r_d.st = ST_TYPE;
                end
                ST_PAY: begin
                    r_d.rem = r_q.rem - LEN_W'(1);
                    if (r_q.rem == LEN_W'(1)) r_d.st = ST_DONE;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= RST_V;
        else        r_q <= r_d;
    end

    assign found      = (r_q.st == ST_PAY) || (r_q.st == ST_DONE);
    assign pay_len    = found ? r_q.len : '0;
    assign err        = (r_q.st == ST_FAIL);
    assign compressed = (r_q.st == ST_GZIP);

endmodule

// File: rtl/bsp_checker.sv
module bsp_checker #(
    parameter int LEN_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic             out_valid,
    input logic             out_ready,
    input logic             found,
    input logic [LEN_W-1:0] pay_len,
    input logic             err,
    input logic             compressed
);
    assert_err_stops_R1: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !in_ready);

    assert_err_sticky_R1: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);

    assert_gzip_halt_R2: assert property (@(posedge clk) disable iff (!rst_n)
        compressed |=> compressed && !in_ready && !err);

    assert_found_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        found |=> found && $stable(pay_len));

    assert_len_zero_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !found |-> pay_len == '0);

    assert_out_needs_found_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> found && in_valid);

    assert_pay_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> in_ready == out_ready);

    assert_flags_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({found, err, compressed}) <= 1);

endmodule

bind bitfile_section_parser bsp_checker #(.LEN_W(LEN_W)) u_bsp_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .found      (found),
    .pay_len    (pay_len),
    .err        (err),
    .compressed (compressed)
);

// File: tb/bitfile_section_parser_tb_top.sv
module bitfile_section_parser_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  sect_sel = 3'd0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = 8'h00;
    logic        in_ready;
    logic        out_valid;
    logic [7:0]  out_data;
    logic        out_ready = 1'b1;
    logic        found;
    logic [31:0] pay_len;
    logic        err;
    logic        compressed;

    int nchk = 0;
    int nfail = 0;
    int cyc = 0;
    bit all_acc;
    logic [7:0] exp_q[$];
    logic [7:0] sig [13] = '{8'h00, 8'h09, 8'h0F, 8'hF0, 8'h0F, 8'hF0, 8'h0F,
                             8'hF0, 8'h0F, 8'hF0, 8'h00, 8'h00, 8'h01};

    always #2 clk = ~clk;

    bitfile_section_parser dut_i (
        .clk(clk), .rst_n(rst_n), .sect_sel(sect_sel),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
        .found(found), .pay_len(pay_len), .err(err), .compressed(compressed)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // downstream ready pattern: off one cycle in three
    always @(posedge clk) begin
        cyc <= cyc + 1;
        #1 out_ready <= (cyc % 3) != 0;
    end

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && out_valid && out_ready) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R9 unexpected payload byte", {24'd0, out_data}, 32'd0);
            end else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                chk(out_data == e, "R9 payload byte", {24'd0, out_data}, {24'd0, e});
            end
        end
    end

    always @(posedge clk) begin
        if (cyc > 150000) begin
            nfail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end

    task automatic do_reset(input logic [2:0] s);
        rst_n    = 1'b0;
        in_valid = 1'b0;
        sect_sel = s;
        exp_q.delete();
        all_acc  = 1'b1;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    task automatic send(input logic [7:0] b, output bit ok);
        ok = 1'b0;
        in_valid = 1'b1;
        in_data  = b;
        for (int k = 0; k < 20; k++) begin
            bit a;
            @(negedge clk);
            a = in_ready;
            @(posedge clk);
            #1;
            if (a) begin
                ok = 1'b1;
                break;
            end
        end
        in_valid = 1'b0;
    endtask

    task automatic put(input logic [7:0] b);
        bit ok;
        send(b, ok);
        if (!ok) all_acc = 1'b0;
    endtask

    task automatic put_sig();
        for (int i = 0; i < 13; i++) put(sig[i]);
    endtask

    task automatic put_hdr(input logic [7:0] t, input int len);
        put(t);
        if (t == 8'h65) begin
            put(len[31:24]);
            put(len[23:16]);
        end
        put(len[15:8]);
        put(len[7:0]);
    endtask

    task automatic put_body(input int n, input bit is_pay, input int seed);
        for (int i = 0; i < n; i++) begin
            logic [7:0] v;
            v = 8'((i * 7 + seed) & 255);
            if (is_pay) exp_q.push_back(v);
            put(v);
        end
    endtask

    task automatic expect_stuck(input string req);
        bit ok;
        send(8'hA5, ok);
        chk(!ok, req, {31'd0, ok}, 32'd0);
    endtask

    task automatic drain_check(input string req);
        repeat (2) @(posedge clk);
        #1;
        chk(exp_q.size() == 0, req, exp_q.size(), 32'd0);
    endtask

    initial begin
        // R10 reset state
        do_reset(3'd4);
        @(negedge clk);
        chk(in_ready == 1'b1, "R10 in_ready after reset", {31'd0, in_ready}, 32'd1);
        chk({found, err, compressed, out_valid} == 4'b0000, "R10 flags after reset",
            {28'd0, found, err, compressed, out_valid}, 32'd0);
        @(posedge clk); #1;

        // R3 R6 R8 R9: skip a and b, find long-length e
        do_reset(3'd4);
        put_sig();
        put_hdr(8'h61, 3); put_body(3, 1'b0, 1);
        put_hdr(8'h62, 2); put_body(2, 1'b0, 5);
        put_hdr(8'h65, 5);
        chk(found && !err, "R8 found after e header", {31'd0, found}, 32'd1);
        chk(pay_len == 32'd5, "R3 long length of e", pay_len, 32'd5);
        put_body(5, 1'b1, 9);
        chk(all_acc, "R6 all bytes accepted", {31'd0, all_acc}, 32'd1);
        drain_check("R9 payload count");
        expect_stuck("R9 no input after payload");
        chk(found && pay_len == 32'd5, "R8 found held", pay_len, 32'd5);

        // R3 R6 match b in the middle, zero-length skip before it
        do_reset(3'd1);
        put_sig();
        put_hdr(8'h61, 0);
        put_hdr(8'h62, 2);
        chk(found && pay_len == 32'd2, "R6 zero-length skip then b", pay_len, 32'd2);
        put_body(2, 1'b1, 40);
        drain_check("R9 payload of b");
        chk(all_acc, "R3 b stream accepted", {31'd0, all_acc}, 32'd1);

        // R9 zero-length match
        do_reset(3'd3);
        put_sig();
        put_hdr(8'h64, 0);
        chk(found && pay_len == 32'd0, "R9 zero-length found", pay_len, 32'd0);
        expect_stuck("R9 zero length forwards nothing");
        chk(exp_q.size() == 0 && !out_valid, "R9 no output", {31'd0, out_valid}, 32'd0);

        // R2 compressed signature
        do_reset(3'd4);
        put(8'h1F); put(8'h8B); put(8'h08);
        chk(compressed && !err, "R2 compressed flag", {30'd0, compressed, err}, 32'd2);
        expect_stuck("R2 stops after signature");

        // R1 signature mismatch at byte 5
        do_reset(3'd4);
        for (int i = 0; i < 5; i++) put(sig[i]);
        put(8'h77);
        chk(err && !found, "R1 mismatch raises err", {31'd0, err}, 32'd1);
        expect_stuck("R1 stops after mismatch");

        // R1 mismatch on first byte
        do_reset(3'd4);
        put(8'h42);
        chk(err == 1'b1, "R1 first byte mismatch", {31'd0, err}, 32'd1);

        // R4 invalid type
        do_reset(3'd4);
        put_sig();
        put(8'h66);
        chk(err == 1'b1, "R4 type f rejected", {31'd0, err}, 32'd1);
        expect_stuck("R4 stops after bad type");

        // R5 short length above 255
        do_reset(3'd4);
        put_sig();
        put(8'h61); put(8'h01);
        chk(!err, "R5 no err before second byte", {31'd0, err}, 32'd0);
        put(8'h00);
        chk(err == 1'b1, "R5 length 256 rejected", {31'd0, err}, 32'd1);

        // R7 search limit exhausted on the 100th byte
        do_reset(3'd2);
        put_sig();
        put_hdr(8'h61, 97);
        put_body(96, 1'b0, 3);
        chk(!err && all_acc, "R7 no err at 99 bytes", {31'd0, err}, 32'd0);
        put_body(1, 1'b0, 11);
        chk(err && all_acc, "R7 err at limit", {31'd0, err}, 32'd1);
        expect_stuck("R7 stops at limit");

        // R7 header completing exactly on the 100th byte is found
        do_reset(3'd2);
        put_sig();
        put_hdr(8'h61, 94); put_body(94, 1'b0, 2);
        put_hdr(8'h63, 2);
        chk(found && !err && pay_len == 32'd2, "R7 match on limit byte", pay_len, 32'd2);
        put_body(2, 1'b1, 77);
        drain_check("R7 payload after limit match");

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

endmodule